// File: doc/BRIEF.md
# Range-Checked Sample-Memory Copy Engine

This engine copies a block of data from an auxiliary sample memory into main memory, eight bytes per beat. A host programs three 32-bit channel registers through a 16-bit register port: the main-memory destination, the auxiliary-memory source and the byte count. Each register is reached as a high half and a low half. The last write, to the low half of the count, launches the copy. A full-width write to the count register launches it as well. Three further registers sit beside the channel registers. An info register holds a 6-bit memory size. A mode register reports that initialization is complete. A refresh register holds a refresh setting.

Every beat first compares the source address with the configured memory size. If the source address is inside the memory, one 64-bit word is read from auxiliary memory and written to main memory, and both addresses advance. If the source address is beyond the end of the memory, nothing is read or written and both addresses hold, but the count still drops by one beat. A stray transfer therefore runs to completion without touching memory that does not exist. The engine raises a one-cycle done pulse when the count is exhausted, for use as the pending flag of a control register.

Top module: `aux_dma`

## Requirements
- R1: After reset the info register reads 0, mode reads 1, refresh reads 156, all channel halves read 0, and busy_o and done_o are low.
- R2: Register selects are: 0 info, 1 mode, 2 refresh, 4/5 main address high/low, 6/7 aux address high/low, 8/9 count high/low. A 16-bit write (reg_wide_i low) uses reg_wdata_i[15:0] and changes only the addressed half. A wide write to select 4, 6 or 8 loads all 32 bits from reg_wdata_i.
- R3: While idle, a 16-bit write to select 9, or a wide write to select 8, starts a transfer. busy_o is high from the next cycle.
- R4: An in-range beat reads the 64-bit word at the aux address and writes that same word to the main address. It then adds 8 to both addresses and subtracts 8 from the count.
- R5: The memory size in bytes is info[5:0] shifted left by SIZE_SHIFT (default 20). A beat whose aux address is at or above that size issues no request on either port and leaves both addresses unchanged, but it subtracts 8 from the count.
- R6: Count bits [2:0] play no part. A transfer has count>>3 beats, and those three bits read back unchanged afterwards.
- R7: A start with count>>3 equal to 0 pulses done_o in the cycle after the start write and issues no memory request.
- R8: done_o is high for exactly one cycle when the beat count reaches zero. busy_o falls in the following cycle.
- R9: aux_req_o and mm_req_o, together with their address and data, hold steady until the matching ready is seen.
- R10: The info register keeps bits [6:0] and reads 0 above them. The mode and refresh registers read back the last value written to them.
- R11: A register write during a transfer is accepted but does not start a new transfer. The running transfer completes with a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wide_i | input | 1 | Write is 32 bits wide (selects 4, 6, 8) |
| reg_sel_i | input | 4 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_sel_i (combinational) |
| aux_req_o | output | 1 | Auxiliary-memory read request |
| aux_addr_o | output | 32 | Auxiliary byte address (current channel value) |
| aux_ready_i | input | 1 | Auxiliary read accepted, data valid |
| aux_rdata_i | input | 64 | Auxiliary read data |
| mm_req_o | output | 1 | Main-memory write request |
| mm_addr_o | output | 32 | Main byte address (current channel value) |
| mm_wdata_o | output | 64 | Main-memory write data |
| mm_ready_i | input | 1 | Main write accepted |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Register reads are combinational, so every readback is taken one time unit after the select is driven at a falling edge. A write is taken at the rising edge that follows the falling edge where it is driven, and the transfer state starts in the cycle after that edge. The zero-count done pulse is therefore looked for at the falling edge that ends the write cycle. Each in-range beat produces an auxiliary request in the cycle after its range check and a main-memory write one cycle after the read is accepted. The responders compare request contents at the falling edge where they raise ready, which is one edge before the handshake. Address and count readbacks are taken only after done has been seen and busy has dropped, when no further update is pending.

// File: rtl/aux_dma_pkg.sv
package aux_dma_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned BEAT_B = 8;

  localparam logic [3:0] SEL_INFO   = 4'd0;
  localparam logic [3:0] SEL_MODE   = 4'd1;
  localparam logic [3:0] SEL_REFR   = 4'd2;
  localparam logic [3:0] SEL_MM_HI  = 4'd4;
  localparam logic [3:0] SEL_MM_LO  = 4'd5;
  localparam logic [3:0] SEL_AUX_HI = 4'd6;
  localparam logic [3:0] SEL_AUX_LO = 4'd7;
  localparam logic [3:0] SEL_CNT_HI = 4'd8;
  localparam logic [3:0] SEL_CNT_LO = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } dma_state_e;
endpackage

// File: rtl/aux_dma_regs.sv
module aux_dma_regs
  import aux_dma_pkg::*;
#(
  parameter int unsigned SIZE_SHIFT  = 20,
  parameter int unsigned REFRESH_RST = 156
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [3:0]        sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              adv_i,
  input  logic              skip_i,
  output logic              start_o,
  output logic [REG_W-1:0]  mm_addr_o,
  output logic [REG_W-1:0]  aux_addr_o,
  output logic [REG_W-1:0]  cnt_o,
  output logic [REG_W:0]    limit_o
);
  localparam int unsigned INFO_W = 7;
  localparam int unsigned SIZE_W = 6;

  logic [INFO_W-1:0] info_q;
  logic [HALF_W-1:0] mode_q, refr_q;
  logic [REG_W-1:0]  mm_q, aux_q, cnt_q;
  logic [HALF_W-1:0] wlo;

  assign wlo = wdata_i[HALF_W-1:0];

  function automatic logic [REG_W-1:0] upd(input logic [REG_W-1:0] cur, input logic hi_hit,
                                           input logic lo_hit, input logic wide,
                                           input logic [REG_W-1:0] wd);
    logic [REG_W-1:0] r;
    r = cur;
    if (hi_hit && wide)  r = wd;
    else if (hi_hit)     r[REG_W-1:HALF_W] = wd[HALF_W-1:0];
    else if (lo_hit)     r[HALF_W-1:0]     = wd[HALF_W-1:0];
    return r;
  endfunction

  logic mm_hit, aux_hit, cnt_hit;
  assign mm_hit  = wr_i && (sel_i == SEL_MM_HI  || sel_i == SEL_MM_LO);
  assign aux_hit = wr_i && (sel_i == SEL_AUX_HI || sel_i == SEL_AUX_LO);
  assign cnt_hit = wr_i && (sel_i == SEL_CNT_HI || sel_i == SEL_CNT_LO);

  assign start_o = wr_i && !busy_i &&
                   ((sel_i == SEL_CNT_LO && !wide_i) || (sel_i == SEL_CNT_HI && wide_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      info_q <= '0;
      mode_q <= HALF_W'(1);
      refr_q <= HALF_W'(REFRESH_RST);
      mm_q   <= '0;
      aux_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i && sel_i == SEL_INFO) info_q <= wlo[INFO_W-1:0];
      if (wr_i && sel_i == SEL_MODE) mode_q <= wlo;
      if (wr_i && sel_i == SEL_REFR) refr_q <= wlo;
      // host write wins over engine update in the same cycle
      if (mm_hit)
        mm_q <= upd(mm_q, sel_i == SEL_MM_HI, sel_i == SEL_MM_LO, wide_i, wdata_i);
      else if (adv_i)
        mm_q <= mm_q + REG_W'(BEAT_B);
      if (aux_hit)
        aux_q <= upd(aux_q, sel_i == SEL_AUX_HI, sel_i == SEL_AUX_LO, wide_i, wdata_i);
      else if (adv_i)
        aux_q <= aux_q + REG_W'(BEAT_B);
      if (cnt_hit)
        cnt_q <= upd(cnt_q, sel_i == SEL_CNT_HI, sel_i == SEL_CNT_LO, wide_i, wdata_i);
      else if (adv_i || skip_i)
        cnt_q <= cnt_q - REG_W'(BEAT_B);
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_INFO:   rdata_o = HALF_W'(info_q);
      SEL_MODE:   rdata_o = mode_q;
      SEL_REFR:   rdata_o = refr_q;
      SEL_MM_HI:  rdata_o = mm_q[REG_W-1:HALF_W];
      SEL_MM_LO:  rdata_o = mm_q[HALF_W-1:0];
      SEL_AUX_HI: rdata_o = aux_q[REG_W-1:HALF_W];
      SEL_AUX_LO: rdata_o = aux_q[HALF_W-1:0];
      SEL_CNT_HI: rdata_o = cnt_q[REG_W-1:HALF_W];
      SEL_CNT_LO: rdata_o = cnt_q[HALF_W-1:0];
      default:    rdata_o = '0;
    endcase
  end

  assign limit_o    = (REG_W+1)'(info_q[SIZE_W-1:0]) << SIZE_SHIFT;
  assign mm_addr_o  = mm_q;
  assign aux_addr_o = aux_q;
  assign cnt_o      = cnt_q;

  AST_SKIP_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i && !wr_i) |=> ($stable(aux_q) && $stable(mm_q))); // R5
  AST_BEAT_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((adv_i || skip_i) && !wr_i) |=> (cnt_q == $past(cnt_q) - REG_W'(BEAT_B))); // R4
  AST_LOW_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((adv_i || skip_i) && !wr_i) |=> (cnt_q[2:0] == $past(cnt_q[2:0]))); // R6
endmodule

// File: rtl/aux_dma_ctrl.sv
module aux_dma_ctrl
  import aux_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_W-1:0]  cnt_i,
  input  logic [REG_W-1:0]  aux_addr_i,
  input  logic [REG_W:0]    limit_i,
  output logic              aux_req_o,
  input  logic              aux_ready_i,
  input  logic [DATA_W-1:0] aux_rdata_i,
  output logic              mm_req_o,
  input  logic              mm_ready_i,
  output logic [DATA_W-1:0] mm_wdata_o,
  output logic              adv_o,
  output logic              skip_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned LSB = $clog2(BEAT_B);

  dma_state_e        st_q, st_d;
  logic [DATA_W-1:0] data_q;
  logic              cnt_zero, in_range;

  assign cnt_zero = (cnt_i[REG_W-1:LSB] == '0);
  assign in_range = ({1'b0, aux_addr_i} < limit_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_CHK;
      ST_CHK:  if (cnt_zero) st_d = ST_IDLE;
               else if (in_range) st_d = ST_RD;
      ST_RD:   if (aux_ready_i) st_d = ST_WR;
      ST_WR:   if (mm_ready_i) st_d = ST_CHK;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RD && aux_ready_i) data_q <= aux_rdata_i;
    end
  end

  assign aux_req_o  = (st_q == ST_RD);
  assign mm_req_o   = (st_q == ST_WR);
  assign mm_wdata_o = data_q;
  assign adv_o      = (st_q == ST_WR) && mm_ready_i;
  assign skip_o     = (st_q == ST_CHK) && !cnt_zero && !in_range;
  assign done_o     = (st_q == ST_CHK) && cnt_zero;
  assign busy_o     = (st_q != ST_IDLE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R8
  AST_AUX_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_req_o && !aux_ready_i) |=> (aux_req_o && $stable(aux_addr_i))); // R9
  AST_MM_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_req_o && !mm_ready_i) |=> (mm_req_o && $stable(mm_wdata_o))); // R9
  AST_AUX_REQ_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_req_o) |-> $past({1'b0, aux_addr_i} < limit_i)); // R5
  AST_NO_REQ_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!aux_req_o && !mm_req_o)); // R7
endmodule

// File: rtl/aux_dma.sv
module aux_dma
  import aux_dma_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned SIZE_SHIFT  = 20,
  parameter int unsigned REFRESH_RST = 156
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_wide_i,
  input  logic [3:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              aux_req_o,
  output logic [31:0]       aux_addr_o,
  input  logic              aux_ready_i,
  input  logic [DATA_W-1:0] aux_rdata_i,
  output logic              mm_req_o,
  output logic [31:0]       mm_addr_o,
  output logic [DATA_W-1:0] mm_wdata_o,
  input  logic              mm_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  logic             start, adv, skip;
  logic [REG_W-1:0] cnt;
  logic [REG_W:0]   limit;

  aux_dma_regs #(
    .SIZE_SHIFT (SIZE_SHIFT),
    .REFRESH_RST(REFRESH_RST)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .wide_i    (reg_wide_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy_o),
    .adv_i     (adv),
    .skip_i    (skip),
    .start_o   (start),
    .mm_addr_o (mm_addr_o),
    .aux_addr_o(aux_addr_o),
    .cnt_o     (cnt),
    .limit_o   (limit)
  );

  aux_dma_ctrl #(
    .DATA_W(DATA_W)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .cnt_i      (cnt),
    .aux_addr_i (aux_addr_o),
    .limit_i    (limit),
    .aux_req_o  (aux_req_o),
    .aux_ready_i(aux_ready_i),
    .aux_rdata_i(aux_rdata_i),
    .mm_req_o   (mm_req_o),
    .mm_ready_i (mm_ready_i),
    .mm_wdata_o (mm_wdata_o),
    .adv_o      (adv),
    .skip_o     (skip),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !busy_o) |=> busy_o); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R11
endmodule

// File: tb/test_aux_dma.sv
module test_aux_dma;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 20;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_wide = 0;
  logic [3:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        aux_req, mm_req, busy, done;
  logic [31:0] aux_addr, mm_addr;
  logic        aux_ready = 0, mm_ready = 0;
  logic [63:0] aux_rdata = 0, mm_wdata;

  int checks = 0, errors = 0;
  int done_cnt = 0, aux_req_cnt = 0;
  int aux_lat = 0, mm_lat = 0;
  logic [32:0] lim_exp = 0;
  logic [95:0] sb_q[$];
  bit finished = 0;

  aux_dma i_aux_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_wide_i(reg_wide), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .aux_req_o(aux_req), .aux_addr_o(aux_addr), .aux_ready_i(aux_ready),
    .aux_rdata_i(aux_rdata),
    .mm_req_o(mm_req), .mm_addr_o(mm_addr), .mm_wdata_o(mm_wdata),
    .mm_ready_i(mm_ready), .busy_o(busy), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr16(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_wide = 0; reg_sel = s; reg_wdata = {16'h0, d};
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr32(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_wide = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wide = 0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [15:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic rd32(input logic [3:0] s_hi, output logic [31:0] d);
    logic [15:0] h, l;
    rd(s_hi, h);
    rd(s_hi + 4'd1, l);
    d = {h, l};
  endtask

  task automatic wait_done(input int snap, input string req);
    int n = 0;
    while (done_cnt == snap && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(req, done_cnt, snap + 1);
    @(negedge clk);
    chk(req, busy, 0);
  endtask

  // driver: program channel, push expected beats, start, await, check results
  task automatic run_xfer(input logic [31:0] mm, input logic [31:0] aux,
                          input logic [31:0] cnt, input bit wide_start, input string req);
    logic [31:0] m = mm, a = aux, r;
    int snap;
    for (int k = 0; k < int'(cnt >> 3); k++) begin
      if ({1'b0, a} < lim_exp) begin
        sb_q.push_back({m, pat(a)});
        m += 8;
        a += 8;
      end
    end
    wr16(4'd4, mm[31:16]);  wr16(4'd5, mm[15:0]);
    wr16(4'd6, aux[31:16]); wr16(4'd7, aux[15:0]);
    snap = done_cnt;
    if (wide_start) wr32(4'd8, cnt);
    else begin
      wr16(4'd8, cnt[31:16]);
      wr16(4'd9, cnt[15:0]);
    end
    wait_done(snap, req);
    chk(req, sb_q.size(), 0);
    sb_q.delete();
    rd32(4'd4, r); chk(req, r, m);
    rd32(4'd6, r); chk(req, r, a);
    rd32(4'd8, r); chk(req, r, {29'h0, cnt[2:0]});
  endtask

  // aux responder, also checks the range rule at each request
  initial begin
    int w = 0;
    forever begin
      @(negedge clk);
      if (aux_ready) aux_ready = 0;
      else if (aux_req) begin
        if (w >= aux_lat) begin
          aux_req_cnt++;
          chk("R5", {31'h0, ({1'b0, aux_addr} < lim_exp)}, 1);
          aux_rdata = pat(aux_addr);
          aux_ready = 1;
          w = 0;
        end else w++;
      end
    end
  end

  // main-memory monitor: pops scoreboard and compares each accepted write
  initial begin
    int w = 0;
    logic [95:0] e;
    forever begin
      @(negedge clk);
      if (mm_ready) mm_ready = 0;
      else if (mm_req) begin
        if (w >= mm_lat) begin
          if (sb_q.size() == 0) chk("R4", {mm_addr, 32'h0}, 64'h0);
          else begin
            e = sb_q.pop_front();
            chk("R4", {32'h0, mm_addr}, {32'h0, e[95:64]});
            chk("R4", mm_wdata, e[63:0]);
          end
          mm_ready = 1;
          w = 0;
        end else w++;
      end
    end
  end

  // done pulse monitor
  initial begin
    logic prev = 0;
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (prev) chk("R8", 1, 0);
      end
      prev = done;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] r;
    int snap, areq;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1", {busy, done}, 0);
    rd(4'd0, d); chk("R1", d, 0);
    rd(4'd1, d); chk("R1", d, 1);
    rd(4'd2, d); chk("R1", d, 156);
    for (int s = 4; s <= 9; s++) begin
      rd(4'(s), d); chk("R1", d, 0);
    end

    // R2 half writes keep the other half, wide write loads both
    wr16(4'd4, 16'h1234); wr16(4'd5, 16'hABCD);
    wr16(4'd4, 16'h5678);
    rd32(4'd4, r); chk("R2", r, 32'h5678_ABCD);
    wr32(4'd6, 32'hDEAD_BEE8);
    rd32(4'd6, r); chk("R2", r, 32'hDEAD_BEE8);

    // R10 info width, mode/refresh readback
    wr16(4'd0, 16'hFFC3); rd(4'd0, d); chk("R10", d, 16'h0043);
    wr16(4'd1, 16'h0000); rd(4'd1, d); chk("R10", d, 0);
    wr16(4'd2, 16'h0099); rd(4'd2, d); chk("R10", d, 16'h0099);

    // R4 in-range copy, size 3 MiB
    wr16(4'd0, 16'h0003); lim_exp = 33'(3) << SHIFT;
    run_xfer(32'h0001_0000, 32'h0000_0100, 32'd24, 0, "R4");
    aux_lat = 2; mm_lat = 3;
    run_xfer(32'h0020_0008, 32'h0010_0040, 32'd40, 0, "R9");

    // R3 wide start
    aux_lat = 0; mm_lat = 1;
    run_xfer(32'h0000_8000, 32'h0000_2000, 32'd16, 1, "R3");

    // R5 crossing the end: 2 beats move, 2 skipped
    wr16(4'd0, 16'h0001); lim_exp = 33'(1) << SHIFT;
    run_xfer(32'h0004_0000, 32'h000F_FFF0, 32'd32, 0, "R5");
    // R5 size zero: all skipped
    wr16(4'd0, 16'h0000); lim_exp = 0;
    areq = aux_req_cnt;
    run_xfer(32'h0005_0000, 32'h0000_0000, 32'd24, 0, "R5");
    chk("R5", aux_req_cnt, areq);

    // R6 low count bits ignored
    wr16(4'd0, 16'h003F); lim_exp = 33'(63) << SHIFT;
    run_xfer(32'h0006_0000, 32'h0000_0800, 32'h0000_001F, 0, "R6");

    // R7 zero-count start: done in the cycle after the start write
    areq = aux_req_cnt;
    snap = done_cnt;
    wr16(4'd8, 16'h0000);
    @(negedge clk);
    reg_wr = 1; reg_sel = 4'd9; reg_wdata = 32'h0000_0005;
    @(negedge clk);
    reg_wr = 0;
    chk("R7", done, 1);
    repeat (3) @(negedge clk);
    chk("R7", done_cnt, snap + 1);
    chk("R7", aux_req_cnt, areq);
    chk("R7", busy, 0);

    // R11 writes during a running transfer
    aux_lat = 4; mm_lat = 4;
    sb_q.push_back({32'h0007_0000, pat(32'h0000_3000)});
    sb_q.push_back({32'h0007_0008, pat(32'h0000_3008)});
    wr16(4'd4, 16'h0007); wr16(4'd5, 16'h0000);
    wr16(4'd6, 16'h0000); wr16(4'd7, 16'h3000);
    wr16(4'd8, 16'h0000);
    snap = done_cnt;
    wr16(4'd9, 16'h0010);
    chk("R3", busy, 1);
    wr16(4'd2, 16'h0055);
    wr16(4'd8, 16'h0000);
    wait_done(snap, "R11");
    chk("R11", sb_q.size(), 0);
    sb_q.delete();
    rd(4'd2, d); chk("R11", d, 16'h0055);
    repeat (5) @(negedge clk);
    chk("R11", done_cnt, snap + 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule